// File: doc/BRIEF.md
# Round-Robin Interrupt Source Selector

This block sits between a set of internal peripheral interrupt lines and a processor's single interrupt input. It registers the raw status of every source once per clock. It combines that status with a software-owned enable mask to form a pending vector. It drives one summary request, which is high while any source is both raised and enabled.

When the interrupt handler pulses a claim strobe, the block returns the index of one pending source. Sources are served in rotation rather than by fixed rank. The search starts from a saved pointer and walks upward, wrapping at the top. The pointer is then left just after the source that was handed out. Over repeated claims every raised source is therefore reached before any source is served twice.

The mask is read back on a dedicated port. It is changed through a write port with four operations: full replace, set selected bits, clear selected bits, and hold. Software can therefore enable or disable single sources without disturbing the others.

Top module: `rr_irq_selector`

## Requirements
- R1: The pending vector is the bitwise AND of the enable mask and the registered status, where status is `src_status` captured at each rising edge. Only a source whose pending bit was set in the cycle of the claim may be returned.
- R2: `irq_req` is high exactly when the pending vector is nonzero. A change on `src_status` reaches `irq_req` after one rising edge, and a mask write also reaches it after one rising edge.
- R3: A claim with the pending vector nonzero raises `claim_valid` for exactly the one cycle after the strobe, with `claim_idx` holding the selected source.
- R4: A claim with the pending vector zero leaves `claim_valid` low in the following cycle and leaves the rotating pointer unchanged.
- R5: The selected source is the first pending index met when walking from the pointer upward: pointer, pointer+1, and so on, modulo NUM_SRC.
- R6: After a successful claim of index k, the pointer equals k+1, wrapping from NUM_SRC-1 to 0. No source is ever favoured over another.
- R7: Write operation code 0 replaces the whole mask with `mask_wr_data`.
- R8: Write operation code 1 sets the mask bits that are 1 in `mask_wr_data` and keeps every other bit.
- R9: Write operation code 2 clears the mask bits that are 1 in `mask_wr_data` and keeps every other bit. Operation code 3 leaves the mask unchanged.
- R10: While `rst_n` is low at a rising edge, the mask becomes all zeros, the pointer becomes 0 and `claim_valid` goes low.
- R11: `mask_rd_data` always shows the current mask, updated at the edge after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_status | input | NUM_SRC | Raw interrupt status lines, one per source |
| mask_wr_en | input | 1 | Mask write strobe |
| mask_wr_op | input | 2 | Write operation: 0 replace, 1 set, 2 clear, 3 hold |
| mask_wr_data | input | NUM_SRC | Write operand |
| mask_rd_data | output | NUM_SRC | Current enable mask |
| claim | input | 1 | Claim strobe from the interrupt handler |
| irq_req | output | 1 | Summary request: any source pending |
| claim_valid | output | 1 | Claim result is valid this cycle |
| claim_idx | output | IDX_W | Index of the claimed source |

## Verification
The assertions assume that `claim` and `mask_wr_en` are single-cycle or multi-cycle levels sampled at rising edges. They assume that `mask_wr_op` holds only the four defined codes. They also assume that the mask and status seen at a claim edge are the values the claim is meant to act on. The bench drives every input at the falling edge, so each strobe is sampled by exactly one rising edge. It changes status one full cycle before claiming, so the registered status has settled. It models the pointer walk with modular arithmetic over many generated status and mask patterns, including dense, sparse, single-bit and empty ones.

// File: rtl/rr_irq_pkg.sv
// Package: shared types for the round-robin interrupt selector.
// Assumes nothing beyond a two-bit write operation field.
package rr_irq_pkg;

    typedef enum logic [1:0] {
        MASK_REPLACE = 2'd0,
        MASK_SET     = 2'd1,
        MASK_CLEAR   = 2'd2,
        MASK_HOLD    = 2'd3
    } mask_op_e;

endpackage

// File: rtl/rr_irq_mask_reg.sv
// Module: enable mask register, one flop per source with its own update rule.
// Assumes a synchronous active-low reset; the operand selects which bits an
// operation touches, so untouched bits always keep their value.
module rr_irq_mask_reg
    import rr_irq_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_op,
    input  logic [NUM_SRC-1:0] wr_data,
    output logic [NUM_SRC-1:0] mask
);

    mask_op_e op;
    assign op = mask_op_e'(wr_op);

    for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
        logic nxt;

        // Purpose: next value of this mask bit for the requested operation.
        always_comb begin
            nxt = mask[b];
            if (wr_en) begin
                unique case (op)
                    MASK_REPLACE: nxt = wr_data[b];
                    MASK_SET:     nxt = mask[b] | wr_data[b];
                    MASK_CLEAR:   nxt = mask[b] & ~wr_data[b];
                    default:      nxt = mask[b];
                endcase
            end
        end

        // Purpose: hold this mask bit, cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n) mask[b] <= 1'b0;
            else        mask[b] <= nxt;
        end
    end

endmodule

// File: rtl/rr_irq_search.sv
// Module: combinational rotating search over the pending vector.
// Rotates the pending vector so the pointer position lands at bit 0, finds
// the lowest set bit, and adds the pointer back modulo NUM_SRC.
// Assumes ptr < NUM_SRC.
module rr_irq_search #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic [NUM_SRC-1:0] pend,
    input  logic [IDX_W-1:0]   ptr,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);

    localparam int SUM_W = IDX_W + 1;

    logic [2*NUM_SRC-1:0] doubled;
    logic [2*NUM_SRC-1:0] shifted;
    logic [NUM_SRC-1:0]   rotated;
    logic [IDX_W-1:0]     offset;
    logic [SUM_W-1:0]     sum;

    assign doubled = {pend, pend};
    assign shifted = doubled >> ptr;
    assign rotated = shifted[NUM_SRC-1:0];
    assign found   = |pend;

    // Purpose: lowest set position of the rotated vector.
    always_comb begin
        offset = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            if (rotated[k]) offset = IDX_W'(k);
        end
    end

    // Purpose: map the offset back to an absolute index, wrapping at NUM_SRC.
    always_comb begin
        sum = SUM_W'(ptr) + SUM_W'(offset);
        if (sum >= SUM_W'(NUM_SRC)) sum = sum - SUM_W'(NUM_SRC);
        idx = sum[IDX_W-1:0];
    end

endmodule

// File: rtl/rr_irq_selector.sv
// Module: top of the round-robin interrupt selector.
// Registers raw status, gates it with the mask, drives the summary request,
// and on a claim returns one pending index one cycle later while advancing
// the rotating pointer just past it. Assumes synchronous active-low reset.
module rr_irq_selector #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_status,
    input  logic               mask_wr_en,
    input  logic [1:0]         mask_wr_op,
    input  logic [NUM_SRC-1:0] mask_wr_data,
    output logic [NUM_SRC-1:0] mask_rd_data,
    input  logic               claim,
    output logic               irq_req,
    output logic               claim_valid,
    output logic [IDX_W-1:0]   claim_idx
);

    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_vec;
    logic [IDX_W-1:0]   ptr_q;
    logic               hit;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   ptr_nxt;

    rr_irq_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mask_wr_en),
        .wr_op   (mask_wr_op),
        .wr_data (mask_wr_data),
        .mask    (mask_q)
    );

    rr_irq_search #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_search (
        .pend  (pend_vec),
        .ptr   (ptr_q),
        .found (hit),
        .idx   (hit_idx)
    );

    // Purpose: capture raw status once per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= src_status;
    end

    assign pend_vec     = status_q & mask_q;
    assign irq_req      = |pend_vec;
    assign mask_rd_data = mask_q;

    // Purpose: pointer value one past the selected index, wrapping.
    always_comb begin
        if (hit_idx == IDX_W'(NUM_SRC - 1)) ptr_nxt = '0;
        else                                ptr_nxt = hit_idx + IDX_W'(1);
    end

    // Purpose: register the claim result and advance the pointer on a hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q       <= '0;
            claim_valid <= 1'b0;
            claim_idx   <= '0;
        end else begin
            claim_valid <= claim & hit;
            if (claim && hit) begin
                claim_idx <= hit_idx;
                ptr_q     <= ptr_nxt;
            end
        end
    end

endmodule

// File: rtl/rr_irq_selector_chk.sv
// Module: assertion checker bound to rr_irq_selector.
// Assumes wr_op only carries the four defined codes.
module rr_irq_selector_chk #(
    parameter int NUM_SRC = 32,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mask_wr_en,
    input logic [1:0]         mask_wr_op,
    input logic [NUM_SRC-1:0] mask_wr_data,
    input logic [NUM_SRC-1:0] mask_rd_data,
    input logic               claim,
    input logic               irq_req,
    input logic               claim_valid,
    input logic [IDX_W-1:0]   claim_idx,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [IDX_W-1:0]   ptr_q
);

    logic [NUM_SRC-1:0] pend_d;

    // Purpose: remember the pending vector of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_d <= '0;
        else        pend_d <= pend_vec;
    end

    assert_claimed_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> pend_d[claim_idx]);

    assert_req_any_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req == (pend_vec != '0));

    assert_hit_gives_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && irq_req) |=> claim_valid);

    assert_valid_needs_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> $past(claim));

    assert_empty_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (claim && !irq_req) |=> (!claim_valid && $stable(ptr_q)));

    assert_ptr_past_idx_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_valid |-> (ptr_q == ((claim_idx == IDX_W'(NUM_SRC - 1)) ? '0 : claim_idx + IDX_W'(1))));

    assert_replace_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_en && mask_wr_op == 2'd0) |=> (mask_rd_data == $past(mask_wr_data)));

    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_en && mask_wr_op == 2'd1) |=>
        (mask_rd_data == ($past(mask_rd_data) | $past(mask_wr_data))));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_en && mask_wr_op == 2'd2) |=>
        (mask_rd_data == ($past(mask_rd_data) & ~$past(mask_wr_data))));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr_en && mask_wr_op == 2'd3) |=> $stable(mask_rd_data));

    assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (mask_rd_data == '0 && ptr_q == '0 && !claim_valid));

endmodule

bind rr_irq_selector rr_irq_selector_chk #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mask_wr_en   (mask_wr_en),
    .mask_wr_op   (mask_wr_op),
    .mask_wr_data (mask_wr_data),
    .mask_rd_data (mask_rd_data),
    .claim        (claim),
    .irq_req      (irq_req),
    .claim_valid  (claim_valid),
    .claim_idx    (claim_idx),
    .pend_vec     (pend_vec),
    .ptr_q        (ptr_q)
);

// File: tb/rr_irq_selector_tb.sv
module rr_irq_selector_tb;

    localparam int N = 32;
    localparam int W = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_status = '0;
    logic         mask_wr_en = 1'b0;
    logic [1:0]   mask_wr_op = 2'd0;
    logic [N-1:0] mask_wr_data = '0;
    logic [N-1:0] mask_rd_data;
    logic         claim = 1'b0;
    logic         irq_req;
    logic         claim_valid;
    logic [W-1:0] claim_idx;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [N-1:0] m_mask = '0;
    logic [N-1:0] m_stat = '0;
    int           m_ptr = 0;
    logic [31:0]  rng = 32'h1234_5678;

    always #10 clk = ~clk;

    rr_irq_selector #(.NUM_SRC(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .src_status(src_status),
        .mask_wr_en(mask_wr_en), .mask_wr_op(mask_wr_op), .mask_wr_data(mask_wr_data),
        .mask_rd_data(mask_rd_data), .claim(claim), .irq_req(irq_req),
        .claim_valid(claim_valid), .claim_idx(claim_idx)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic write_mask(input logic [1:0] op, input logic [N-1:0] d);
        mask_wr_en = 1'b1; mask_wr_op = op; mask_wr_data = d;
        @(negedge clk);
        mask_wr_en = 1'b0;
        case (op)
            2'd0: m_mask = d;
            2'd1: m_mask = m_mask | d;
            2'd2: m_mask = m_mask & ~d;
            default: m_mask = m_mask;
        endcase
        check(mask_rd_data == m_mask, (op == 2'd0) ? "R7/R11" : (op == 2'd1) ? "R8/R11" : "R9/R11",
              64'(mask_rd_data), 64'(m_mask));
    endtask

    task automatic set_status(input logic [N-1:0] s);
        src_status = s;
        m_stat = s;
        @(negedge clk);
        check(irq_req == ((m_stat & m_mask) != '0), "R2", 64'(irq_req), 64'((m_stat & m_mask) != '0));
    endtask

    task automatic do_claim();
        logic [N-1:0] pend;
        bit exp_v;
        int exp_i;
        pend = m_stat & m_mask;
        exp_v = (pend != '0);
        exp_i = 0;
        if (exp_v) begin
            for (int k = 0; k < N; k++) begin
                if (pend[(m_ptr + k) % N]) begin
                    exp_i = (m_ptr + k) % N;
                    break;
                end
            end
        end
        claim = 1'b1;
        @(negedge clk);
        claim = 1'b0;
        if (exp_v) begin
            check(claim_valid == 1'b1, "R3", 64'(claim_valid), 64'(1));
            check(int'(claim_idx) == exp_i, "R5/R1", 64'(claim_idx), 64'(exp_i));
            m_ptr = (exp_i + 1) % N;
        end else begin
            check(claim_valid == 1'b0, "R4", 64'(claim_valid), 64'(0));
        end
        @(negedge clk);
        check(claim_valid == 1'b0, "R3 single cycle", 64'(claim_valid), 64'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(mask_rd_data == '0, "R10 mask", 64'(mask_rd_data), 64'(0));
        check(claim_valid == 1'b0, "R10 valid", 64'(claim_valid), 64'(0));
        check(irq_req == 1'b0, "R10 req", 64'(irq_req), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R4: status raised but all masked: claim returns nothing, pointer stays at 0
        set_status('1);
        do_claim();
        // R6: full sweep with everything pending, wrap from N-1 back to 0
        write_mask(2'd0, '1);
        for (int r = 0; r < N + 3; r++) do_claim();
        check(m_ptr == 3, "R6 wrap", 64'(m_ptr), 64'(3));

        // R8/R9: set and clear preserve other bits; op 3 is ignored
        write_mask(2'd0, 32'h0000_00F0);
        write_mask(2'd1, 32'h8000_0001);
        write_mask(2'd2, 32'h0000_0030);
        write_mask(2'd3, 32'hFFFF_FFFF);
        check(mask_rd_data == 32'h8000_00C1, "R9 hold", 64'(mask_rd_data), 64'h8000_00C1);

        // R1: masked source never claimed; single source repeated
        set_status(32'h0000_0101);
        write_mask(2'd0, 32'h0000_0100);
        do_claim();
        do_claim();
        // R4: empty pending after a hit leaves the pointer where it was
        set_status('0);
        do_claim();
        set_status(32'h0000_0201);
        write_mask(2'd0, '1);
        do_claim();
        check(m_ptr == 10, "R4 pointer kept", 64'(m_ptr), 64'(10));

        // Pattern sweep: dense, sparse and single-bit patterns
        for (int p = 0; p < 300; p++) begin
            logic [N-1:0] s;
            logic [N-1:0] m;
            rng = next_rand(rng); s = rng;
            rng = next_rand(rng); m = rng;
            if (p % 3 == 1) begin rng = next_rand(rng); s = s & rng; m = m & ~rng; end
            if (p % 3 == 2) s = N'(1) << (p % N);
            write_mask(2'(p % 3), m);
            set_status(s);
            for (int c = 0; c < 6; c++) do_claim();
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule